// File: doc/BRIEF.md
# Comparator Timer Channel with Periodic Reload

This block is one channel of an event timer. It watches a free-running main counter that is shared by all channels. When the counter reaches the channel's comparator, the channel emits a one-cycle match pulse. A matching interrupt-request pulse is also emitted when the channel's interrupt enable is set. The channel keeps comparing and reloading while its interrupt is disabled. The interrupt enable only decides whether the interrupt pulse leaves the block.

In periodic mode, a hidden period register steps the comparator forward after each match. The comparator advances by one period per clock until it again lies ahead of the counter. A write to the comparator location is steered by the mode and by a set-value bit that clears itself. In one-shot mode, or with set-value set, the write lands in the comparator. In periodic mode with set-value clear, the write lands in the period register. A narrow mode limits the comparator to its low 32 bits and decides "reached" from the sign of the wrapped 32-bit difference.

The block has no bus logic of its own. The owner of the channel drives full-width write strobes with data and reads the config and comparator values back on two output buses. The main counter and the global enable come from the timer block that contains the channel.

Top module: `tmr_chan`

## Requirements
- R1: After reset the config readback is 0x0030 (only bits 4 and 5 set), the comparator reads all ones, and match and interrupt outputs are low.
- R2: A config write changes only the bits in mask 0x3F4E. Bits 4 and 5 always read 1. Every other bit outside the mask reads 0 and keeps its value.
- R3: A comparator write lands in the comparator when periodic mode (config bit 3) is clear or set-value (config bit 6) is set. Otherwise it lands in the period register, and the comparator readback is unchanged.
- R4: Every comparator write clears config bit 6.
- R5: While narrow mode (config bit 8) is set, comparator and period writes keep only the low 32 bits. Turning narrow mode on clears the upper 32 bits of the stored comparator in the same cycle.
- R6: In one-shot mode, match_o pulses for exactly one cycle, in the cycle after the first cycle in which the counter is at or above the comparator (unsigned). The pulse does not repeat, and the comparator value stays unchanged.
- R7: irq_o equals match_o gated by config bit 2. With bit 2 clear, matches and periodic reloads still take place.
- R8: While glb_en_i is low, match_o and irq_o stay low.
- R9: In periodic mode with a nonzero period, each match adds the period to the comparator. The add repeats once per cycle while the counter is still at or past the comparator. Each such catch-up produces a single match pulse.
- R10: In periodic mode with a zero period, the comparator is not reloaded and the channel matches once.
- R11: In narrow mode the counter has reached the comparator when the low 32 bits of counter minus comparator are non-negative as a signed value. Reloads wrap the comparator at 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| counter_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global enable for matching and reload |
| cfg_wr_i | input | 1 | Config register write strobe |
| cfg_wdata_i | input | 16 | Config write data |
| cmp_wr_i | input | 1 | Comparator location write strobe |
| cmp_wdata_i | input | 64 | Comparator or period write data |
| match_o | output | 1 | One-cycle match pulse |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| cfg_rd_o | output | 16 | Config register readback |
| cmp_rd_o | output | 64 | Comparator readback |

## Verification
If the arm flag ends up in the wrong state, the block emits a pulse one cycle early or late, repeats a one-shot pulse, or leaves a catch-up sequence silent. All of these show on match_o one cycle after the counter is presented. If the period register or the comparator routing is wrong, the comparator readback is wrong at the next period boundary, and the pulse spacing drifts from that point on. The sweeps step the counter one value per cycle, in both wide and narrow mode and across a 32-bit wrap. Each cycle's pulse is compared against an arithmetic prediction, so any such error is caught on the cycle it first appears.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int CFG_BITS = 16;

    localparam int BIT_LEVEL  = 1;
    localparam int BIT_IRQEN  = 2;
    localparam int BIT_PERIOD = 3;
    localparam int BIT_SETVAL = 6;
    localparam int BIT_NARROW = 8;

    localparam logic [CFG_BITS-1:0] CFG_WR_MASK = 16'h3F4E;
    localparam logic [CFG_BITS-1:0] CFG_RO_ONES = 16'h0030;

    typedef struct packed {
        logic narrow;
        logic setval;
        logic periodic;
        logic irq_en;
        logic level;
    } chan_mode_t;

    typedef enum logic [1:0] {
        DEST_NONE,
        DEST_COMPARE,
        DEST_PERIOD
    } wr_dest_e;

    function automatic chan_mode_t decode_mode(input logic [CFG_BITS-1:0] c);
        chan_mode_t m;
        m.narrow   = c[BIT_NARROW];
        m.setval   = c[BIT_SETVAL];
        m.periodic = c[BIT_PERIOD];
        m.irq_en   = c[BIT_IRQEN];
        m.level    = c[BIT_LEVEL];
        return m;
    endfunction

    function automatic wr_dest_e route_write(input logic wr, input chan_mode_t m);
        if (!wr)
            return DEST_NONE;
        else if (!m.periodic || m.setval)
            return DEST_COMPARE;
        else
            return DEST_PERIOD;
    endfunction

endpackage

// File: rtl/tmr_chan_cfg.sv
module tmr_chan_cfg
    import tmr_chan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    input  logic                clr_setval,
    output logic [CFG_BITS-1:0] cfg_q,
    output chan_mode_t          mode_q,
    output chan_mode_t          mode_nx
);

    logic [CFG_BITS-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr)
            cfg_d = (cfg_wdata & CFG_WR_MASK) | (cfg_q & ~CFG_WR_MASK);
        if (clr_setval)
            cfg_d[BIT_SETVAL] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RO_ONES;
        else
            cfg_q <= cfg_d;
    end

    assign mode_q  = decode_mode(cfg_q);
    assign mode_nx = decode_mode(cfg_d);

endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_dest_e         dest,
    input  logic [CNT_W-1:0] wdata,
    input  chan_mode_t       mode_q,
    input  chan_mode_t       mode_nx,
    input  logic             glb_en,
    input  logic             reached,
    output logic [CNT_W-1:0] cmp_q
);

    localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'({NARROW_W{1'b1}});

    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cmp_d;
    logic [CNT_W-1:0] per_d;
    logic [CNT_W-1:0] wdata_fit;
    logic             reload;

    assign wdata_fit = mode_nx.narrow ? (wdata & LOW_MASK) : wdata;
    assign reload    = glb_en && mode_q.periodic && (per_q != '0) && reached;

    always_comb begin
        cmp_d = cmp_q;
        per_d = per_q;
        unique case (dest)
            DEST_COMPARE: cmp_d = wdata_fit;
            DEST_PERIOD:  per_d = wdata_fit;
            default: begin
                if (reload)
                    cmp_d = cmp_q + per_q;
            end
        endcase
        if (mode_nx.narrow)
            cmp_d = cmp_d & LOW_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cmp_q <= cmp_d;
            per_q <= per_d;
        end
    end

endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] counter,
    input  logic [CNT_W-1:0] cmp,
    input  chan_mode_t       mode_q,
    input  logic             glb_en,
    input  logic             cmp_written,
    output logic             reached,
    output logic             match,
    output logic             irq
);

    logic wide_reach;
    logic narrow_reach;
    logic armed_q;
    logic fire;

    assign wide_reach = (counter >= cmp);

    generate
        if (NARROW_W < CNT_W) begin : g_narrow
            logic [NARROW_W-1:0] diff;
            assign diff         = counter[NARROW_W-1:0] - cmp[NARROW_W-1:0];
            assign narrow_reach = ~diff[NARROW_W-1];
        end else begin : g_full
            assign narrow_reach = wide_reach;
        end
    endgenerate

    assign reached = mode_q.narrow ? narrow_reach : wide_reach;
    assign fire    = glb_en && reached && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            match   <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (cmp_written)
                armed_q <= 1'b1;
            else if (fire)
                armed_q <= 1'b0;
            else if (!reached)
                armed_q <= 1'b1;
            match <= fire;
            irq   <= fire && mode_q.irq_en;
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    counter_i,
    input  logic                glb_en_i,
    input  logic                cfg_wr_i,
    input  logic [CFG_BITS-1:0] cfg_wdata_i,
    input  logic                cmp_wr_i,
    input  logic [CNT_W-1:0]    cmp_wdata_i,
    output logic                match_o,
    output logic                irq_o,
    output logic [CFG_BITS-1:0] cfg_rd_o,
    output logic [CNT_W-1:0]    cmp_rd_o
);

    chan_mode_t       mode_q;
    chan_mode_t       mode_nx;
    wr_dest_e         dest;
    logic             reached;
    logic [CNT_W-1:0] cmp_q;

    assign dest = route_write(cmp_wr_i, mode_q);

    tmr_chan_cfg i_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr_i),
        .cfg_wdata  (cfg_wdata_i),
        .clr_setval (cmp_wr_i),
        .cfg_q      (cfg_rd_o),
        .mode_q     (mode_q),
        .mode_nx    (mode_nx)
    );

    tmr_chan_cmp #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) i_cmp (
        .clk     (clk),
        .rst     (rst),
        .dest    (dest),
        .wdata   (cmp_wdata_i),
        .mode_q  (mode_q),
        .mode_nx (mode_nx),
        .glb_en  (glb_en_i),
        .reached (reached),
        .cmp_q   (cmp_q)
    );

    tmr_chan_match #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) i_match (
        .clk         (clk),
        .rst         (rst),
        .counter     (counter_i),
        .cmp         (cmp_q),
        .mode_q      (mode_q),
        .glb_en      (glb_en_i),
        .cmp_written (cmp_wr_i),
        .reached     (reached),
        .match       (match_o),
        .irq         (irq_o)
    );

    assign cmp_rd_o = cmp_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NARROW_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                glb_en_i,
    input logic                cfg_wr_i,
    input logic                cmp_wr_i,
    input logic                match_o,
    input logic                irq_o,
    input logic [CFG_BITS-1:0] cfg_rd_o,
    input logic [CNT_W-1:0]    cmp_rd_o
);

    AST_CFG_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_o & ~CFG_WR_MASK) == CFG_RO_ONES); // R2

    AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmp_wr_i |=> !cfg_rd_o[BIT_SETVAL]); // R4

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_o[BIT_NARROW] |-> (cmp_rd_o[CNT_W-1:NARROW_W] == '0)); // R5

    AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (match_o && !$past(cmp_wr_i)) |=> !match_o); // R6

    AST_ONESHOT_CMP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rd_o[BIT_PERIOD] && !cmp_wr_i && !cfg_wr_i) |=> $stable(cmp_rd_o)); // R6

    AST_IRQ_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> match_o); // R7

    AST_NO_MATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !glb_en_i |=> (!match_o && !irq_o)); // R8

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .glb_en_i (glb_en_i),
    .cfg_wr_i (cfg_wr_i),
    .cmp_wr_i (cmp_wr_i),
    .match_o  (match_o),
    .irq_o    (irq_o),
    .cfg_rd_o (cfg_rd_o),
    .cmp_rd_o (cmp_rd_o)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] counter_i = '0;
    logic        glb_en_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        cmp_wr_i = 1'b0;
    logic [63:0] cmp_wdata_i = '0;
    logic        match_o;
    logic        irq_o;
    logic [15:0] cfg_rd_o;
    logic [63:0] cmp_rd_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_chan i_tmr_chan (
        .clk         (clk),
        .rst         (rst),
        .counter_i   (counter_i),
        .glb_en_i    (glb_en_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cmp_wr_i    (cmp_wr_i),
        .cmp_wdata_i (cmp_wdata_i),
        .match_o     (match_o),
        .irq_o       (irq_o),
        .cfg_rd_o    (cfg_rd_o),
        .cmp_rd_o    (cmp_rd_o)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = v;
        cyc();
        cfg_wr_i = 1'b0;
    endtask

    task automatic wr_cmp(input logic [63:0] v);
        cmp_wr_i = 1'b1;
        cmp_wdata_i = v;
        cyc();
        cmp_wr_i = 1'b0;
    endtask

    task automatic prep(input logic [15:0] cfg, input logic [63:0] cnt0);
        glb_en_i = 1'b0;
        counter_i = cnt0;
        wr_cfg(cfg);
    endtask

    // One counter value per cycle; expected pulse at index first, then every step (0 = once).
    task automatic sweep(input logic [63:0] base, input int n, input int first,
                         input int step, input bit ien, input string req);
        for (int k = 0; k < n; k++) begin
            bit exp;
            counter_i = base + 64'(k);
            cyc();
            if (first < 0 || k < first)
                exp = 1'b0;
            else if (step == 0)
                exp = (k == first);
            else
                exp = ((k - first) % step) == 0;
            chk({63'd0, match_o}, {63'd0, exp}, req, $sformatf("match at k=%0d", k));
            chk({63'd0, irq_o}, {63'd0, exp & ien}, req, $sformatf("irq at k=%0d", k));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        chk(64'(cfg_rd_o), 64'h0030, "R1", "cfg after reset");
        chk(cmp_rd_o, '1, "R1", "cmp after reset");
        chk({62'd0, match_o, irq_o}, 64'd0, "R1", "pulses after reset");

        // R2 write mask and fixed bits
        wr_cfg(16'hFFFF);
        chk(64'(cfg_rd_o), 64'h3F7E, "R2", "cfg all ones written");
        wr_cfg(16'h0000);
        chk(64'(cfg_rd_o), 64'h0030, "R2", "cfg zeros written");

        // R6 one-shot wide: single pulse at 20, comparator untouched
        prep(16'h0004, 64'd0);
        wr_cmp(64'd20);
        chk(cmp_rd_o, 64'd20, "R3", "one-shot write lands in comparator");
        glb_en_i = 1'b1;
        sweep(64'd0, 31, 20, 0, 1'b1, "R6");
        chk(cmp_rd_o, 64'd20, "R6", "one-shot comparator unchanged");

        // R8 no match while global enable clear
        prep(16'h0004, 64'd0);
        wr_cmp(64'd20);
        sweep(64'd0, 31, -1, 0, 1'b0, "R8");

        // R9 periodic with routing and set-value clearing
        prep(16'h004C, 64'd0);
        wr_cmp(64'd10);
        chk(64'(cfg_rd_o), 64'h003C, "R4", "set-value cleared after write");
        wr_cmp(64'd8);
        chk(cmp_rd_o, 64'd10, "R3", "periodic write goes to period");
        glb_en_i = 1'b1;
        sweep(64'd0, 51, 10, 8, 1'b1, "R9");
        chk(cmp_rd_o, 64'd58, "R9", "comparator after periodic run");

        // R7 interrupt disabled: matches and reloads continue
        prep(16'h0048, 64'd0);
        wr_cmp(64'd4);
        wr_cmp(64'd5);
        glb_en_i = 1'b1;
        sweep(64'd0, 21, 4, 5, 1'b0, "R7");
        chk(cmp_rd_o, 64'd24, "R7", "reload with interrupt disabled");

        // R9 catch-up: counter held far past comparator
        prep(16'h004C, 64'd130);
        wr_cmp(64'd100);
        wr_cmp(64'd7);
        glb_en_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc();
            chk({63'd0, match_o}, {63'd0, (i == 0)}, "R9", $sformatf("catch-up pulse cycle %0d", i));
        end
        chk(cmp_rd_o, 64'd135, "R9", "comparator after catch-up");

        // R10 zero period
        prep(16'h004C, 64'd0);
        wr_cmp(64'd5);
        wr_cmp(64'd0);
        glb_en_i = 1'b1;
        sweep(64'd0, 21, 5, 0, 1'b1, "R10");
        chk(cmp_rd_o, 64'd5, "R10", "no reload with zero period");

        // R5 truncation on mode switch and on write
        prep(16'h0000, 64'd0);
        wr_cmp(64'h1_0000_0020);
        chk(cmp_rd_o, 64'h1_0000_0020, "R5", "wide write keeps upper bits");
        wr_cfg(16'h0104);
        chk(cmp_rd_o, 64'h20, "R5", "switch to narrow truncates");
        wr_cmp(64'hAAAA_BBBB_0000_0020);
        chk(cmp_rd_o, 64'h20, "R5", "narrow write truncates");

        // R11 narrow compare ignores upper counter bits
        counter_i = 64'h5_0000_0000;
        glb_en_i = 1'b1;
        sweep(64'h5_0000_0000, 49, 32, 0, 1'b1, "R11");

        // R11 narrow periodic across 32-bit wrap
        prep(16'h014C, 64'hFFFF_FFE8);
        wr_cmp(64'hFFFF_FFF0);
        wr_cmp(64'h20);
        glb_en_i = 1'b1;
        sweep(64'hFFFF_FFE8, 65, 8, 32, 1'b1, "R11");
        chk(cmp_rd_o, 64'h30, "R11", "comparator wrapped at 32 bits");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule